// File: doc/BRIEF.md
# Chained Row-Buffer Serial-to-Parallel Converter

This block takes a raster stream of pixels, one per enabled cycle, and presents the same column of several consecutive image rows side by side. A sliding window that is several rows tall can then be loaded one column per cycle without reading any memory itself. Storage is a ring of single-row buffers that all use the same address. Each buffer, when written, takes the value that its upstream neighbour held at that address. A new row therefore pushes every stored row one buffer further down the chain.

The row length is an input. It is read on every enabled cycle, so it can change between frames without rebuilding the block. Reads are registered. The address read on one cycle is written on the next, with the incoming pixel delayed by one register to line up. The valid flag rises only after the chain holds a full set of rows.

Top module: `row_chain_s2p`

## Requirements
- R1: After reset is released, `lanes_valid` is low, the column address is 0 and the count of completed rows is 0. The first pixel accepted after reset is taken as row 0, column 0.
- R2: A pixel is accepted only on a cycle with `pix_en` high. A cycle with `pix_en` low does not move the column position and stores nothing. Its `pix_in` value never appears on a lane, and `lanes_valid` is low on the cycle after it.
- R3: The column position advances by one per accepted pixel and wraps to column 0 after column `row_len`-1. `row_len` may be any value from `LANES` to `DEPTH`.
- R4: Let an accepted pixel belong to row r and column c. On the cycle after it is accepted, lane k (bits `k*PW` upward) carries the pixel of row r-1-k at column c. Lane 0 holds the most recent complete row.
- R5: `lanes_valid` is high on the cycle after an accepted pixel whose row index r is at least `LANES`. It is low in every other cycle.
- R6: The completed-row count saturates at `LANES`. Streaming can continue for any number of rows, and every row from index `LANES` onward yields exactly `row_len` valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | PW | Incoming pixel |
| pix_en | input | 1 | High when `pix_in` carries a pixel |
| row_len | input | AW+1 | Pixels per row, from LANES to DEPTH |
| lanes | output | LANES*PW | One column of LANES rows; lane k at bits k*PW upward |
| lanes_valid | output | 1 | High when all lanes hold real rows |

## Verification
On every cycle, the assertions check how the column address moves: one step per accepted pixel, a hold on idle cycles, and a wrap at the configured end of row. They also check that the row count saturates and that the valid flag rises only once a full chain of rows is loaded. They cannot check which stored row ends up on which lane, because that depends on data written a whole row earlier. The bench scenarios show this by streaming known patterns at several row lengths, including the smallest and the largest, with and without idle gaps. They then compare every lane against the row that should be there.

// File: rtl/row_chain_s2p.sv
module row_chain_s2p #(
  parameter int LANES = 7,
  parameter int DEPTH = 256,
  parameter int PW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       pix_in,
  input  logic                pix_en,
  input  logic [LW-1:0]       row_len,
  output logic [LANES*PW-1:0] lanes,
  output logic                lanes_valid
);

  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wr_addr;
  logic          wr_en;
  logic [PW-1:0] pix_d;
  logic [CW-1:0] row_cnt;
  logic [PW-1:0] q_a [LANES];

  wire last_col = {1'b0, rd_addr} >= (row_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr     <= '0;
      wr_en       <= 1'b0;
      row_cnt     <= '0;
      lanes_valid <= 1'b0;
    end else begin
      wr_en       <= pix_en;
      lanes_valid <= pix_en && (row_cnt == CW'(LANES));
      if (pix_en) begin
        rd_addr <= last_col ? '0 : rd_addr + 1'b1;
        if (last_col && row_cnt != CW'(LANES))
          row_cnt <= row_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    wr_addr <= rd_addr;
    pix_d   <= pix_in;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_buf
    logic [PW-1:0] mem [DEPTH];
    logic [PW-1:0] wdat;
    if (k == 0) begin : g_head
      assign wdat = pix_d;
    end else begin : g_link
      assign wdat = q_a[k-1];
    end
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wdat;
      q_a[k] <= mem[rd_addr];
    end
    assign lanes[k*PW +: PW] = q_a[k];
  end

endmodule

module row_chain_s2p_chk #(
  parameter int AW = 8,
  parameter int LW = 9,
  parameter int LANES = 7,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic [LW-1:0] row_len,
  input logic [AW-1:0] rd_addr,
  input logic [CW-1:0] row_cnt,
  input logic          lanes_valid
);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && ({1'b0, rd_addr} < row_len - 1'b1)) |=> rd_addr == $past(rd_addr) + 1'b1);

  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && ({1'b0, rd_addr} >= row_len - 1'b1)) |=> rd_addr == '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(rd_addr));

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> !lanes_valid);

  assert_rows_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_cnt <= CW'(LANES));

  assert_valid_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lanes_valid) |-> row_cnt == CW'(LANES));

endmodule

bind row_chain_s2p row_chain_s2p_chk #(.AW(AW), .LW(LW), .LANES(LANES), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .row_len(row_len),
  .rd_addr(rd_addr), .row_cnt(row_cnt), .lanes_valid(lanes_valid)
);

// File: tb/row_chain_s2p_test.sv
module row_chain_s2p_test;
  localparam int PERIOD = 10;
  localparam int K = 4;
  localparam int D = 16;
  localparam int PW = 8;
  localparam int LW = $clog2(D) + 1;

  logic clk = 0;
  logic rst_n = 0;
  logic [PW-1:0] pix_in = '0;
  logic pix_en = 0;
  logic [LW-1:0] row_len = LW'(K);
  logic [K*PW-1:0] lanes;
  logic lanes_valid;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  row_chain_s2p #(.LANES(K), .DEPTH(D), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_en(pix_en),
    .row_len(row_len), .lanes(lanes), .lanes_valid(lanes_valid)
  );

  // fields: row_len, rows, gap flag, seed. R3 spans K..D; R6 uses long streams
  localparam logic [31:0] TV [6] = '{
    {8'd4,  8'd6,  8'd0, 8'd1},
    {8'd6,  8'd7,  8'd0, 8'd2},
    {8'd16, 8'd5,  8'd0, 8'd3},
    {8'd9,  8'd8,  8'd1, 8'd4},
    {8'd5,  8'd12, 8'd0, 8'd5},
    {8'd4,  8'd6,  8'd1, 8'd6}
  };

  function automatic logic [PW-1:0] pv(int r, int c, int s);
    return PW'(r * 37 + c * 5 + s * 11 + 3);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 0;
    pix_en = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check(lanes_valid == 1'b0, "R1 valid after reset", 64'(lanes_valid), 64'd0);
  endtask

  task automatic stream(int rl, int rows, bit gap, int s, output int nvalid);
    nvalid = 0;
    row_len = LW'(rl);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < rl; c++) begin
        @(negedge clk);
        pix_en = 1;
        pix_in = pv(r, c, s);
        @(posedge clk);
        #1;
        if (lanes_valid) nvalid++;
        check(lanes_valid == (r >= K), "R5 valid timing", 64'(lanes_valid), 64'(r >= K));
        if (r >= K) begin
          for (int k = 0; k < K; k++)
            check(lanes[k*PW +: PW] == pv(r - 1 - k, c, s), "R4/R3 lane content",
                  64'(lanes[k*PW +: PW]), 64'(pv(r - 1 - k, c, s)));
        end
        if (gap) begin
          @(negedge clk);
          pix_en = 0;
          pix_in = 8'hA5;
          @(posedge clk);
          #1;
          check(lanes_valid == 1'b0, "R2 idle cycle valid", 64'(lanes_valid), 64'd0);
        end
      end
    end
    @(negedge clk);
    pix_en = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int nv;
    for (int i = 0; i < 6; i++) begin
      do_reset();
      stream(int'(TV[i][31:24]), int'(TV[i][23:16]), TV[i][8], int'(TV[i][7:0]), nv);
      check(nv == (int'(TV[i][23:16]) - K) * int'(TV[i][31:24]), "R6 valid count",
            64'(nv), 64'((int'(TV[i][23:16]) - K) * int'(TV[i][31:24])));
    end
    // R1: reset mid-stream restarts the row count and column position
    do_reset();
    stream(6, 3, 0, 7, nv);
    do_reset();
    stream(7, 6, 0, 8, nv);
    check(nv == 2 * 7, "R1 restart valid count", 64'(nv), 64'(14));
    finish_run();
  end
endmodule